// File: doc/BRIEF.md
# Convolution Layer Descriptor Controller

This block is the control point between a host processor and two convolution engines, one for 1x1 (pointwise) work and one for 3x3 per-channel (depthwise) work. Over a plain memory-mapped register port the host loads one layer's descriptor. The descriptor holds the square tensor edge length, the input channel count, an operation selector, ReLU and batch-norm enables, a stride code, and three external-memory base addresses for input data, output data and weights.

The host starts a layer by writing 1 to the go register. The block then copies the descriptor into an active copy that drives the engine-side ports, and checks it against the legal limits. A legal descriptor gets a one-cycle start pulse on the engine that the selector picks. An illegal one gets no engine at all. When the selected engine reports done, or at once for an illegal descriptor, the block sets a ready flag. The host polls this flag before it loads the next layer. While a layer is in flight, the register file is locked.

The sequencer has six states. ST_IDLE waits for go. ST_LATCH copies the descriptor. ST_CHECK validates it. ST_LAUNCH pulses a start. ST_WAIT waits for done. ST_FINISH sets ready and returns to idle. The transitions are:
- go accepted: ST_IDLE to ST_LATCH
- always: ST_LATCH to ST_CHECK
- legal: ST_CHECK to ST_LAUNCH
- illegal: ST_CHECK to ST_FINISH
- always: ST_LAUNCH to ST_WAIT
- matching done: ST_WAIT to ST_FINISH
- always: ST_FINISH to ST_IDLE

Top module: `layer_desc_ctrl`

## Requirements
- R1: After reset every register reads 0, the ready and error flags are 0, and neither start output is asserted.
- R2: Register map. A write loads the register and a read returns it:
  - 0x00: edge length in bits [7:0].
  - 0x04: channel count in bits [10:0].
  - 0x08: operation selector in bits [1:0], ReLU enable in bit 4, batch-norm enable in bit 5, stride code in bits [9:8].
  - 0x10: input base, 32 bits.
  - 0x14: output base, 32 bits.
  - 0x18: weight base, 32 bits.
- R3: A write with bit 0 set to offset 0x0C, made while idle, copies the whole descriptor to the engine-side outputs and clears the ready flag. Offset 0x0C then reads bit 0 = 1 until the layer ends.
- R4: Selector 0 gives one single-cycle pulse on pw_start, and selector 1 gives one on dw_start. The two starts are never high together.
- R5: Offset 0x1C bit 0 (ready) stays 0 while an engine runs. It is set only after the done input of the started engine; the other engine's done is ignored.
- R6: Selector 2 or 3 sets the error flag (0x1C bit 1) and the ready flag without any start pulse.
- R7: An edge length above 160, a channel count above 1024, or a stride code of 1 or 3 is rejected as in R6. The values 160, 1024 and stride code 2 are accepted.
- R8: Writes to any register, including a second go, while a layer is in flight are ignored. Readback is unchanged afterwards and no extra start occurs.
- R9: eng_relu and eng_bn follow the copied enable bits. eng_stride2 is 1 exactly when the copied stride code is 2.
- R10: A new go clears the error flag of a rejected layer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pw_start | output | 1 | Pointwise engine start pulse |
| dw_start | output | 1 | Depthwise engine start pulse |
| pw_done | input | 1 | Pointwise engine done pulse |
| dw_done | input | 1 | Depthwise engine done pulse |
| eng_size | output | 8 | Copied tensor edge length |
| eng_chan | output | 11 | Copied channel count |
| eng_relu | output | 1 | Copied ReLU enable |
| eng_bn | output | 1 | Copied batch-norm enable |
| eng_stride2 | output | 1 | Copied stride is 2 |
| eng_in_base | output | 32 | Copied input base address |
| eng_out_base | output | 32 | Copied output base address |
| eng_kern_base | output | 32 | Copied weight base address |

## Verification
A sequencer stuck in the wrong state shows at the ports within one polling interval. Either the ready bit never returns, or the go register reads busy forever, or a start pulse appears that the scoreboard never queued. A wrong copy or decode shows up on the very start pulse: the scoreboard compares every engine-side field against the descriptor it pushed at that exact cycle. Faulty validation or lock logic shows as a status of 3 where 1 was expected, or as changed readback after a layer ends.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

    localparam int DATA_W = 32;
    localparam int SIZE_W = 8;
    localparam int CHAN_W = 11;
    localparam int OP_W   = 2;
    localparam int STR_W  = 2;

    // register byte offsets
    localparam int OFF_SIZE = 'h00;
    localparam int OFF_CHAN = 'h04;
    localparam int OFF_CTRL = 'h08;
    localparam int OFF_GO   = 'h0C;
    localparam int OFF_IN   = 'h10;
    localparam int OFF_OUT  = 'h14;
    localparam int OFF_KERN = 'h18;
    localparam int OFF_STAT = 'h1C;

    // control word bit positions
    localparam int CTRL_OP_LO  = 0;
    localparam int CTRL_RELU   = 4;
    localparam int CTRL_BN     = 5;
    localparam int CTRL_STR_LO = 8;

    localparam logic [OP_W-1:0]  OP_PW    = 2'd0;
    localparam logic [OP_W-1:0]  OP_DW    = 2'd1;
    localparam logic [STR_W-1:0] STR_ONE  = 2'd0;
    localparam logic [STR_W-1:0] STR_TWO  = 2'd2;

    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [CHAN_W-1:0] chan;
        logic [OP_W-1:0]   op;
        logic              relu;
        logic              bn;
        logic [STR_W-1:0]  stride;
        logic [DATA_W-1:0] in_base;
        logic [DATA_W-1:0] out_base;
        logic [DATA_W-1:0] kern_base;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_CHECK,
        ST_LAUNCH,
        ST_WAIT,
        ST_FINISH
    } seq_state_t;

endpackage

// File: rtl/ldc_regfile.sv
module ldc_regfile
    import ldc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock,
    input  logic              fab_rdy,
    input  logic              err_flag,
    output desc_t             shadow,
    output logic              go_pulse,
    output logic [DATA_W-1:0] rdata
);

    logic wr_ok;

    assign wr_ok    = wr_en && !lock;
    assign go_pulse = wr_ok && (addr == REG_AW'(OFF_GO)) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_ok) begin
            unique case (addr)
                REG_AW'(OFF_SIZE): shadow.size <= wdata[SIZE_W-1:0];
                REG_AW'(OFF_CHAN): shadow.chan <= wdata[CHAN_W-1:0];
                REG_AW'(OFF_CTRL): begin
                    shadow.op     <= wdata[CTRL_OP_LO +: OP_W];
                    shadow.relu   <= wdata[CTRL_RELU];
                    shadow.bn     <= wdata[CTRL_BN];
                    shadow.stride <= wdata[CTRL_STR_LO +: STR_W];
                end
                REG_AW'(OFF_IN):   shadow.in_base   <= wdata;
                REG_AW'(OFF_OUT):  shadow.out_base  <= wdata;
                REG_AW'(OFF_KERN): shadow.kern_base <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_AW'(OFF_SIZE): rdata[SIZE_W-1:0] = shadow.size;
            REG_AW'(OFF_CHAN): rdata[CHAN_W-1:0] = shadow.chan;
            REG_AW'(OFF_CTRL): begin
                rdata[CTRL_OP_LO +: OP_W]   = shadow.op;
                rdata[CTRL_RELU]            = shadow.relu;
                rdata[CTRL_BN]              = shadow.bn;
                rdata[CTRL_STR_LO +: STR_W] = shadow.stride;
            end
            REG_AW'(OFF_GO):   rdata[0] = lock;
            REG_AW'(OFF_IN):   rdata = shadow.in_base;
            REG_AW'(OFF_OUT):  rdata = shadow.out_base;
            REG_AW'(OFF_KERN): rdata = shadow.kern_base;
            REG_AW'(OFF_STAT): rdata[1:0] = {err_flag, fab_rdy};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/ldc_validate.sv
module ldc_validate
    import ldc_pkg::*;
#(
    parameter int SIZE_MAX = 160,
    parameter int CHAN_MAX = 1024
) (
    input  desc_t desc,
    output logic  legal,
    output logic  pick_dw
);

    logic op_ok;
    logic size_ok;
    logic chan_ok;
    logic str_ok;

    always_comb begin
        op_ok   = (desc.op == OP_PW) || (desc.op == OP_DW);
        size_ok = 32'(desc.size) <= SIZE_MAX;
        chan_ok = 32'(desc.chan) <= CHAN_MAX;
        str_ok  = (desc.stride == STR_ONE) || (desc.stride == STR_TWO);
        legal   = op_ok && size_ok && chan_ok && str_ok;
        pick_dw = (desc.op == OP_DW);
    end

endmodule

// File: rtl/ldc_seq.sv
module ldc_seq
    import ldc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_pulse,
    input  logic legal,
    input  logic pick_dw,
    input  logic pw_done,
    input  logic dw_done,
    output logic latch_en,
    output logic pw_start,
    output logic dw_start,
    output logic busy,
    output logic fab_rdy,
    output logic err_flag
);

    seq_state_t state;
    seq_state_t nxt;
    logic       done_hit;

    assign done_hit = pick_dw ? dw_done : pw_done;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go_pulse) nxt = ST_LATCH;
            ST_LATCH:  nxt = ST_CHECK;
            ST_CHECK:  nxt = legal ? ST_LAUNCH : ST_FINISH;
            ST_LAUNCH: nxt = ST_WAIT;
            ST_WAIT:   if (done_hit) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        latch_en = (state == ST_LATCH);
        pw_start = (state == ST_LAUNCH) && !pick_dw;
        dw_start = (state == ST_LAUNCH) &&  pick_dw;
        busy     = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fab_rdy  <= 1'b0;
            err_flag <= 1'b0;
        end else if (go_pulse) begin
            fab_rdy  <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (state == ST_CHECK && !legal) err_flag <= 1'b1;
            if (state == ST_FINISH)          fab_rdy  <= 1'b1;
        end
    end

endmodule

// File: rtl/layer_desc_ctrl.sv
module layer_desc_ctrl
    import ldc_pkg::*;
#(
    parameter int SIZE_MAX = 160,
    parameter int CHAN_MAX = 1024,
    parameter int REG_AW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pw_start,
    output logic              dw_start,
    input  logic              pw_done,
    input  logic              dw_done,
    output logic [SIZE_W-1:0] eng_size,
    output logic [CHAN_W-1:0] eng_chan,
    output logic              eng_relu,
    output logic              eng_bn,
    output logic              eng_stride2,
    output logic [DATA_W-1:0] eng_in_base,
    output logic [DATA_W-1:0] eng_out_base,
    output logic [DATA_W-1:0] eng_kern_base
);

    desc_t shadow;
    desc_t active;
    logic  go_pulse;
    logic  latch_en;
    logic  legal;
    logic  pick_dw;
    logic  busy;
    logic  fab_rdy;
    logic  err_flag;

    ldc_regfile #(.REG_AW(REG_AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .lock     (busy),
        .fab_rdy  (fab_rdy),
        .err_flag (err_flag),
        .shadow   (shadow),
        .go_pulse (go_pulse),
        .rdata    (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        active <= '0;
        else if (latch_en) active <= shadow;
    end

    ldc_validate #(.SIZE_MAX(SIZE_MAX), .CHAN_MAX(CHAN_MAX)) u_val (
        .desc    (active),
        .legal   (legal),
        .pick_dw (pick_dw)
    );

    ldc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_pulse (go_pulse),
        .legal    (legal),
        .pick_dw  (pick_dw),
        .pw_done  (pw_done),
        .dw_done  (dw_done),
        .latch_en (latch_en),
        .pw_start (pw_start),
        .dw_start (dw_start),
        .busy     (busy),
        .fab_rdy  (fab_rdy),
        .err_flag (err_flag)
    );

    assign eng_size      = active.size;
    assign eng_chan      = active.chan;
    assign eng_relu      = active.relu;
    assign eng_bn        = active.bn;
    assign eng_stride2   = (active.stride == STR_TWO);
    assign eng_in_base   = active.in_base;
    assign eng_out_base  = active.out_base;
    assign eng_kern_base = active.kern_base;

endmodule

// File: rtl/ldc_props.sv
module ldc_props
    import ldc_pkg::*;
#(
    parameter int SIZE_MAX = 160,
    parameter int CHAN_MAX = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pw_start,
    input logic              dw_start,
    input logic              fab_rdy,
    input logic              err_flag,
    input logic              busy,
    input logic [OP_W-1:0]   act_op,
    input logic [SIZE_W-1:0] eng_size,
    input logic [CHAN_W-1:0] eng_chan,
    input logic [DATA_W-1:0] eng_in_base
);

    AST_START_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pw_start && dw_start)); // R4
    AST_PW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pw_start |=> !pw_start); // R4
    AST_DW_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dw_start |=> !dw_start); // R4
    AST_PW_OP: assert property (@(posedge clk) disable iff (!rst_n)
        pw_start |-> act_op == OP_PW); // R4
    AST_DW_OP: assert property (@(posedge clk) disable iff (!rst_n)
        dw_start |-> act_op == OP_DW); // R4
    AST_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_start || dw_start) |-> (32'(eng_size) <= SIZE_MAX && 32'(eng_chan) <= CHAN_MAX)); // R7
    AST_ERR_NOSTART: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !(pw_start || dw_start)); // R6
    AST_RDY_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_start || dw_start) |=> !fab_rdy); // R5
    AST_DESC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(busy, 2)) |->
            ($stable(eng_size) && $stable(eng_chan) && $stable(eng_in_base))); // R8

endmodule

bind layer_desc_ctrl ldc_props #(.SIZE_MAX(SIZE_MAX), .CHAN_MAX(CHAN_MAX)) u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .pw_start    (pw_start),
    .dw_start    (dw_start),
    .fab_rdy     (fab_rdy),
    .err_flag    (err_flag),
    .busy        (busy),
    .act_op      (active.op),
    .eng_size    (eng_size),
    .eng_chan    (eng_chan),
    .eng_in_base (eng_in_base)
);

// File: tb/sim_layer_desc_ctrl.sv
`timescale 1ns/1ps
module sim_layer_desc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pw_start, dw_start;
    logic        pw_done, dw_done;
    logic [7:0]  eng_size;
    logic [10:0] eng_chan;
    logic        eng_relu, eng_bn, eng_stride2;
    logic [31:0] eng_in_base, eng_out_base, eng_kern_base;

    logic auto_pw = 1'b0, auto_dw = 1'b0;
    logic man_pw = 1'b0, man_dw = 1'b0;
    bit   auto_done = 1'b1;
    int   done_wait = 0;
    bit   last_dw = 1'b0;
    int   n_chk = 0;
    int   n_fail = 0;

    assign pw_done = auto_pw | man_pw;
    assign dw_done = auto_dw | man_dw;

    always #2 clk = ~clk;

    layer_desc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pw_start(pw_start), .dw_start(dw_start),
        .pw_done(pw_done), .dw_done(dw_done),
        .eng_size(eng_size), .eng_chan(eng_chan), .eng_relu(eng_relu),
        .eng_bn(eng_bn), .eng_stride2(eng_stride2), .eng_in_base(eng_in_base),
        .eng_out_base(eng_out_base), .eng_kern_base(eng_kern_base)
    );

    typedef struct packed {
        bit          dw;
        logic [7:0]  size;
        logic [10:0] chan;
        bit          relu;
        bit          bn;
        bit          s2;
        logic [31:0] ib;
        logic [31:0] ob;
        logic [31:0] kb;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // engine model and scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        auto_pw = 1'b0;
        auto_dw = 1'b0;
        if (done_wait > 0) begin
            done_wait--;
            if (done_wait == 0) begin
                if (last_dw) auto_dw = 1'b1;
                else         auto_pw = 1'b1;
            end
        end
        if (rst_n && (pw_start || dw_start)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8 unexpected start", {30'd0, dw_start, pw_start}, 32'd0);
            end else begin
                e = sb.pop_front();
                chk(!(pw_start && dw_start) && (dw_start == e.dw), "R4 engine select", {30'd0, dw_start, pw_start}, {31'd0, e.dw});
                chk(eng_size == e.size, "R3 size copy", 32'(eng_size), 32'(e.size));
                chk(eng_chan == e.chan, "R3 chan copy", 32'(eng_chan), 32'(e.chan));
                chk({eng_relu, eng_bn, eng_stride2} == {e.relu, e.bn, e.s2}, "R9 flags",
                    {29'd0, eng_relu, eng_bn, eng_stride2}, {29'd0, e.relu, e.bn, e.s2});
                chk(eng_in_base == e.ib, "R3 in base", eng_in_base, e.ib);
                chk(eng_out_base == e.ob, "R3 out base", eng_out_base, e.ob);
                chk(eng_kern_base == e.kb, "R3 kern base", eng_kern_base, e.kb);
            end
            last_dw = dw_start;
            if (auto_done) done_wait = 12;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic load(input int sz, input int ch, input int op, input bit relu, input bit bn,
                        input int str, input logic [31:0] ib, input logic [31:0] ob, input logic [31:0] kb);
        wr(5'h00, 32'(sz));
        wr(5'h04, 32'(ch));
        wr(5'h08, (32'(op) & 32'h3) | (32'(relu) << 4) | (32'(bn) << 5) | ((32'(str) & 32'h3) << 8));
        wr(5'h10, ib);
        wr(5'h14, ob);
        wr(5'h18, kb);
    endtask

    task automatic push(input bit dw, input int sz, input int ch, input bit relu, input bit bn,
                        input bit s2, input logic [31:0] ib, input logic [31:0] ob, input logic [31:0] kb);
        exp_t e;
        e.dw = dw; e.size = 8'(sz); e.chan = 11'(ch); e.relu = relu; e.bn = bn; e.s2 = s2;
        e.ib = ib; e.ob = ob; e.kb = kb;
        sb.push_back(e);
    endtask

    task automatic wait_done(input string req, input logic [31:0] exp_stat);
        logic [31:0] v;
        v = '0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            rd(5'h1C, v);
            if (v[0]) break;
        end
        chk(v == exp_stat, req, v, exp_stat);
        rd(5'h0C, v);
        chk(v == 32'd0, {req, " go idle"}, v, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v);
            chk(v == 32'd0, "R1 reset readback", v, 32'd0);
        end
        chk(!pw_start && !dw_start, "R1 no start", {30'd0, dw_start, pw_start}, 32'd0);

        // R2 map readback
        load(80, 32, 0, 1, 0, 0, 32'h1000_0000, 32'h2000_0000, 32'h3000_0000);
        rd(5'h00, v); chk(v == 32'd80, "R2 size", v, 32'd80);
        rd(5'h04, v); chk(v == 32'd32, "R2 chan", v, 32'd32);
        rd(5'h08, v); chk(v == 32'h10, "R2 ctrl", v, 32'h10);
        rd(5'h18, v); chk(v == 32'h3000_0000, "R2 kern", v, 32'h3000_0000);

        // R3/R4/R5 pointwise layer
        push(1'b0, 80, 32, 1, 0, 0, 32'h1000_0000, 32'h2000_0000, 32'h3000_0000);
        wr(5'h0C, 32'd1);
        rd(5'h0C, v); chk(v == 32'd1, "R3 go reads busy", v, 32'd1);
        rd(5'h1C, v); chk(v == 32'd0, "R5 ready low while running", v, 32'd0);
        wait_done("R5 pw ready", 32'd1);

        // R7 boundaries accepted, depthwise, R8 writes while busy ignored
        load(160, 1024, 1, 0, 1, 2, 32'hA000_0040, 32'hB000_0080, 32'hC000_00C0);
        push(1'b1, 160, 1024, 0, 1, 1, 32'hA000_0040, 32'hB000_0080, 32'hC000_00C0);
        wr(5'h0C, 32'd1);
        wr(5'h00, 32'd5);
        wr(5'h10, 32'hDEAD_BEEF);
        wr(5'h0C, 32'd1);
        wait_done("R7 boundary ready", 32'd1);
        rd(5'h00, v); chk(v == 32'd160, "R8 size unchanged", v, 32'd160);
        rd(5'h10, v); chk(v == 32'hA000_0040, "R8 base unchanged", v, 32'hA000_0040);
        repeat (20) @(negedge clk);
        chk(sb.size() == 0, "R8 single start", 32'(sb.size()), 32'd0);

        // R6 bad selector
        load(40, 16, 2, 0, 0, 0, 32'h1, 32'h2, 32'h3);
        wr(5'h0C, 32'd1);
        wait_done("R6 op 2 error", 32'd3);
        wr(5'h08, 32'h3);
        wr(5'h0C, 32'd1);
        wait_done("R6 op 3 error", 32'd3);

        // R7 rejections
        load(161, 16, 0, 0, 0, 0, 32'h1, 32'h2, 32'h3);
        wr(5'h0C, 32'd1);
        wait_done("R7 size 161", 32'd3);
        load(40, 1025, 0, 0, 0, 0, 32'h1, 32'h2, 32'h3);
        wr(5'h0C, 32'd1);
        wait_done("R7 chan 1025", 32'd3);
        load(40, 16, 0, 0, 0, 1, 32'h1, 32'h2, 32'h3);
        wr(5'h0C, 32'd1);
        wait_done("R7 stride 1", 32'd3);
        wr(5'h08, 32'h300);
        wr(5'h0C, 32'd1);
        wait_done("R7 stride 3", 32'd3);

        // R10 error cleared by next good layer; R9 relu+bn, stride 1
        load(10, 8, 0, 1, 1, 0, 32'h4, 32'h8, 32'hC);
        push(1'b0, 10, 8, 1, 1, 0, 32'h4, 32'h8, 32'hC);
        wr(5'h0C, 32'd1);
        rd(5'h1C, v); chk(v == 32'd0, "R10 error cleared at go", v, 32'd0);
        wait_done("R10 good after error", 32'd1);

        // R5 other engine's done ignored
        auto_done = 1'b0;
        push(1'b0, 10, 8, 1, 1, 0, 32'h4, 32'h8, 32'hC);
        wr(5'h0C, 32'd1);
        repeat (5) @(negedge clk);
        man_dw = 1'b1;
        @(negedge clk);
        man_dw = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'h1C, v); chk(v == 32'd0, "R5 wrong done ignored", v, 32'd0);
        rd(5'h0C, v); chk(v == 32'd1, "R5 still busy", v, 32'd1);
        man_pw = 1'b1;
        @(negedge clk);
        man_pw = 1'b0;
        wait_done("R5 matching done", 32'd1);
        chk(sb.size() == 0, "R4 all starts seen", 32'(sb.size()), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule